// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps a 32-bit effective address onto a physical address through a small set of large, fixed-size translation windows. It keeps two independent tables of entries, one for instruction fetches and one for data loads and stores. Each entry is a pair of 32-bit words. The upper word holds the window's effective base, its length mask and two privilege enables. The lower word holds the physical base and a two-bit protection code.

Software-side logic fills the entries one word at a time through a write port. A request presents an address, an access kind and a privilege level. Exactly one clock later the unit answers with one of three results: a hit carrying the translated address, a protection fault, or a miss. On a miss the surrounding logic falls back to page-level translation.

Top module: `bxl_matcher`

## Requirements
- R1: After reset every entry in both tables is invalid, so every request misses until an entry is written.
- R2: An entry matches only when address bits 31:28 equal upper-word bits 31:28 and address bits 27:17, with the masked bits cleared, equal upper-word bits 27:17.
- R3: Upper-word bits 12:2 form the length mask and line up with address bits 27:17. A set mask bit removes that address bit from the comparison.
- R4: Upper-word bit 1 enables the entry for supervisor requests (`req_user`=0). Upper-word bit 0 enables it for user requests (`req_user`=1).
- R5: Lower-word bits 1:0 set the protection. Code 0 denies every access. Code 2 allows load, store and fetch. Codes 1 and 3 allow load and fetch and deny stores.
- R6: On a hit, the physical address is built from three parts. Bits 31:28 come from lower-word bits 31:28. Bits 27:17 are (address AND mask) OR lower-word bits 27:17. Bits 16:0 are address bits 16:0.
- R7: An entry that matches the address but is not enabled for the request's privilege is skipped, and the search continues with higher indices.
- R8: The lowest-index entry that matches and is enabled decides the result. If it denies the access, the response is a fault, even when a later entry would allow it.
- R9: `req_kind` 2'b10 (fetch) searches only the instruction table (`wr_side`=1). Kinds 2'b00 and 2'b11 (load) and 2'b01 (store) search only the data table (`wr_side`=0).
- R10: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. Hit and fault are never both high. `rsp_paddr` is zero unless hit is high. All response outputs are zero when `rsp_valid` is low.
- R11: A write to an entry takes effect at the clock edge. A request in the same cycle as the write sees the entry's old contents. `wr_hi`=1 selects the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_side | input | 1 | Table select: 1 instruction, 0 data |
| wr_idx | input | 2 | Entry index |
| wr_hi | input | 1 | Word select: 1 upper, 0 lower |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Effective address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| req_user | input | 1 | 1 user, 0 supervisor |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Matching entry denied the access |
| rsp_paddr | output | 32 | Physical address on hit, else zero |

## Verification
The bench programs entries that overlap the same window with different privilege enables and protections. This exercises two failure modes: a design that stops at a privilege-disabled match would miss where it should hit, and one that keeps searching after a denial would return a hit where a fault is due. Length masks are checked against addresses that differ only inside or only outside the masked bits; a mask shifted by one position turns hits into misses or corrupts the middle physical bits. Writes issued in the same cycle as requests expose a table that forwards new contents too early. Fetch-versus-data cases catch a swapped table select. A random phase compares every response against a behavioural model.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD     = 2'b00,
      KIND_STORE    = 2'b01,
      KIND_FETCH    = 2'b10,
      KIND_LOAD_ALT = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic [31:0] up;
      logic [31:0] lo;
   } entry_t;

   localparam int unsigned PROT_NONE = 0;
   localparam int unsigned PROT_RWX  = 2;
endpackage

// File: rtl/bxl_entry_bank.sv
module bxl_entry_bank #(
   parameter int N_ENTRY = 4,
   parameter int IDX_W   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic                              wr_hi,
   input  logic [31:0]                       wr_data,
   output bxl_pkg::entry_t [N_ENTRY-1:0]     ents_o
);
   bxl_pkg::entry_t [N_ENTRY-1:0] ents_q;

   for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
      logic hit_w;
      assign hit_w = wr_en && (32'(wr_idx) == e);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ents_q[e] <= '0;
         end else if (hit_w) begin
            if (wr_hi) ents_q[e].up <= wr_data;
            else       ents_q[e].lo <= wr_data;
         end
      end
   end

   assign ents_o = ents_q;
endmodule

// File: rtl/bxl_entry_cmp.sv
module bxl_entry_cmp (
   input  bxl_pkg::entry_t ent,
   input  logic [31:0]     addr,
   input  logic            is_store,
   input  logic            user,
   output logic            sel,
   output logic            allow,
   output logic [31:0]     paddr
);
   logic [10:0] blen;
   logic        match;
   logic        priv_ok;
   logic [1:0]  pp;
   logic        unused_bits;

   assign blen    = ent.up[12:2];
   assign match   = (addr[31:28] == ent.up[31:28]) &&
                    ((addr[27:17] & ~blen) == ent.up[27:17]);
   assign priv_ok = user ? ent.up[0] : ent.up[1];
   assign sel     = match && priv_ok;
   assign pp      = ent.lo[1:0];
   assign allow   = is_store ? (32'(pp) == bxl_pkg::PROT_RWX)
                             : (32'(pp) != bxl_pkg::PROT_NONE);
   assign paddr   = {ent.lo[31:28], (addr[27:17] & blen) | ent.lo[27:17], addr[16:0]};
   assign unused_bits = ^{ent.up[16:13], ent.lo[16:2]};
endmodule

// File: rtl/bxl_prio_pick.sv
module bxl_prio_pick #(
   parameter int N_ENTRY = 4
) (
   input  logic [N_ENTRY-1:0]       sel,
   input  logic [N_ENTRY-1:0]       allow,
   input  logic [N_ENTRY-1:0][31:0] paddr,
   output logic                     hit,
   output logic                     fault,
   output logic [31:0]              pa
);
   always_comb begin
      hit   = 1'b0;
      fault = 1'b0;
      pa    = '0;
      for (int i = N_ENTRY - 1; i >= 0; i--) begin
         if (sel[i]) begin
            hit   = allow[i];
            fault = !allow[i];
            pa    = allow[i] ? paddr[i] : '0;
         end
      end
   end
endmodule

// File: rtl/bxl_matcher.sv
module bxl_matcher #(
   parameter int N_ENTRY = 4,
   localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_side,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_hi,
   input  logic [31:0]      wr_data,
   input  logic             req_valid,
   input  logic [31:0]      req_addr,
   input  logic [1:0]       req_kind,
   input  logic             req_user,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_fault,
   output logic [31:0]      rsp_paddr
);
   import bxl_pkg::*;

   if (N_ENTRY < 1 || N_ENTRY > 16) begin : g_bad_cfg
      $error("bxl_matcher: N_ENTRY must lie in 1..16");
   end

   localparam int N_SIDE = 2;

   entry_t [N_SIDE-1:0][N_ENTRY-1:0] bank_ents;

   for (genvar s = 0; s < N_SIDE; s++) begin : g_side
      logic side_we;
      assign side_we = wr_en && (wr_side == s[0]);
      bxl_entry_bank #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (side_we),
         .wr_idx  (wr_idx),
         .wr_hi   (wr_hi),
         .wr_data (wr_data),
         .ents_o  (bank_ents[s])
      );
   end

   logic                     is_fetch;
   logic                     is_store;
   entry_t [N_ENTRY-1:0]     act_ents;
   logic [N_ENTRY-1:0]       e_sel;
   logic [N_ENTRY-1:0]       e_allow;
   logic [N_ENTRY-1:0][31:0] e_pa;
   logic                     p_hit;
   logic                     p_fault;
   logic [31:0]              p_pa;

   assign is_fetch = (req_kind == KIND_FETCH);
   assign is_store = (req_kind == KIND_STORE);
   assign act_ents = is_fetch ? bank_ents[1] : bank_ents[0];

   for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
      bxl_entry_cmp i_cmp (
         .ent      (act_ents[e]),
         .addr     (req_addr),
         .is_store (is_store),
         .user     (req_user),
         .sel      (e_sel[e]),
         .allow    (e_allow[e]),
         .paddr    (e_pa[e])
      );
   end

   bxl_prio_pick #(.N_ENTRY(N_ENTRY)) i_pick (
      .sel   (e_sel),
      .allow (e_allow),
      .paddr (e_pa),
      .hit   (p_hit),
      .fault (p_fault),
      .pa    (p_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && p_hit;
         rsp_fault <= req_valid && p_fault;
         rsp_paddr <= req_valid ? p_pa : '0;
      end
   end
endmodule

// File: rtl/bxl_matcher_chk.sv
module bxl_matcher_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [31:0] req_addr,
   input logic        rsp_valid,
   input logic        rsp_hit,
   input logic        rsp_fault,
   input logic [31:0] rsp_paddr
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R10
   AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fault)); // R8
   AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_paddr == 32'h0)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_fault)); // R10
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_paddr[16:0] == $past(req_addr[16:0]))); // R6
endmodule

bind bxl_matcher bxl_matcher_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr)
);

// File: tb/test_bxl_matcher.sv
module test_bxl_matcher;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_side = 1'b0, wr_hi = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0, req_user = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [31:0] rsp_paddr;

   int tests = 0, fails = 0;
   logic [31:0] m_up [2][4];
   logic [31:0] m_lo [2][4];

   always #(CLK_PERIOD/2) clk = ~clk;

   bxl_matcher i_bxl_matcher (.*);

   task automatic model(input logic [1:0] kind, input logic user, input logic [31:0] a,
                        output logic h, output logic f, output logic [31:0] p);
      int side = (kind == 2'b10) ? 1 : 0;
      h = 0; f = 0; p = 0;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] u = m_up[side][i];
         logic [31:0] l = m_lo[side][i];
         logic [10:0] m = u[12:2];
         bit ok_priv = user ? u[0] : u[1];
         if (a[31:28] == u[31:28] && (a[27:17] & ~m) == u[27:17] && ok_priv) begin
            bit ok = (kind == 2'b01) ? (l[1:0] == 2) : (l[1:0] != 0);
            h = ok; f = !ok;
            if (ok) p = {l[31:28], (a[27:17] & m) | l[27:17], a[16:0]};
            return;
         end
      end
   endtask

   task automatic cyc(input logic we, input logic ws, input logic [1:0] wi, input logic wh,
                      input logic [31:0] wd, input logic rv, input logic [1:0] rk,
                      input logic ru, input logic [31:0] ra, input string tag);
      logic eh, ef; logic [31:0] ep;
      wr_en = we; wr_side = ws; wr_idx = wi; wr_hi = wh; wr_data = wd;
      req_valid = rv; req_kind = rk; req_user = ru; req_addr = ra;
      model(rk, ru, ra, eh, ef, ep);
      if (!rv) begin eh = 0; ef = 0; ep = 0; end
      if (we) begin
         if (wh) m_up[ws][wi] = wd; else m_lo[ws][wi] = wd;
      end
      @(posedge clk); @(negedge clk);
      tests++;
      if (rsp_valid !== rv || rsp_hit !== eh || rsp_fault !== ef || rsp_paddr !== ep) begin
         fails++;
         $display("FAIL %s: got v=%b h=%b f=%b pa=%h, expected v=%b h=%b f=%b pa=%h",
                  tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, rv, eh, ef, ep);
      end
   endtask

   task automatic wr(input logic s, input logic [1:0] i, input logic h, input logic [31:0] d,
                     input string tag);
      cyc(1, s, i, h, d, 0, 2'b00, 0, 0, tag);
   endtask

   task automatic rq(input logic [1:0] k, input logic u, input logic [31:0] a, input string tag);
      cyc(0, 0, 0, 0, 0, 1, k, u, a, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 4; i++) begin m_up[s][i] = 0; m_lo[s][i] = 0; end
      repeat (3) @(negedge clk);
      tests++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         fails++; $display("FAIL R1: reset response got v=%b expected v=0", rsp_valid);
      end
      rst_n = 1'b1;
      // R1: empty tables miss
      rq(2'b00, 0, 32'h1000_1234, "R1");
      rq(2'b10, 1, 32'h0000_0000, "R1");
      // data entry 0: window 0x1000_0000, both privileges, RWX
      wr(0, 0, 1, 32'h1000_0003, "R11");
      wr(0, 0, 0, 32'h8000_0002, "R11");
      rq(2'b00, 0, 32'h1000_1234, "R6");
      rq(2'b01, 1, 32'h1001_FFFF, "R5");
      rq(2'b11, 1, 32'h1000_0ABC, "R9");
      rq(2'b10, 0, 32'h1000_1234, "R9");
      rq(2'b00, 0, 32'h1002_0000, "R2");
      rq(2'b00, 0, 32'h2000_0000, "R2");
      // data entry 1: 0x3000_0000, mask on bits 20:17, user only, RX
      wr(0, 1, 1, 32'h3000_003D, "R3");
      wr(0, 1, 0, 32'h5000_0001, "R3");
      rq(2'b00, 1, 32'h301A_5432, "R3");
      rq(2'b00, 1, 32'h3006_5432, "R3");
      rq(2'b01, 1, 32'h301A_5432, "R5");
      rq(2'b00, 0, 32'h301A_5432, "R4");
      // data entry 2: same window, supervisor only, RWX
      wr(0, 2, 1, 32'h3000_003E, "R7");
      wr(0, 2, 0, 32'h6000_0002, "R7");
      rq(2'b00, 0, 32'h301A_5432, "R7");
      rq(2'b01, 0, 32'h3010_0000, "R7");
      // data entry 3: same window, both privileges, RWX
      wr(0, 3, 1, 32'h3000_003F, "R8");
      wr(0, 3, 0, 32'h7000_0002, "R8");
      rq(2'b01, 1, 32'h301A_5432, "R8");
      rq(2'b00, 1, 32'h301A_5432, "R8");
      // instruction entry 0: protection code 0 then 3
      wr(1, 0, 1, 32'h4000_0003, "R9");
      wr(1, 0, 0, 32'h9000_0000, "R5");
      rq(2'b10, 0, 32'h4000_0010, "R5");
      wr(1, 0, 0, 32'h9000_0003, "R5");
      rq(2'b10, 1, 32'h4000_0010, "R5");
      rq(2'b00, 0, 32'h4000_0010, "R9");
      // R11: write and request in the same cycle
      cyc(1, 0, 0, 1, 32'h0, 1, 2'b00, 0, 32'h1000_1234, "R11");
      rq(2'b00, 0, 32'h1000_1234, "R11");
      // random phase against the model
      for (int n = 0; n < 600; n++) begin
         logic [3:0] nib [4] = '{4'h1, 4'h3, 4'h4, 4'h7};
         logic [31:0] wd = $urandom;
         logic [31:0] ra = $urandom;
         bit we = ($urandom % 4) == 0;
         bit rv = ($urandom % 4) != 0;
         wd[31:28] = nib[$urandom % 4];
         if ($urandom % 2) wd[27:17] = wd[27:17] & ~wd[12:2];
         ra[31:28] = nib[$urandom % 4];
         cyc(we, 1'($urandom), 2'($urandom), 1'($urandom), wd,
             rv, 2'($urandom), 1'($urandom), ra, "R10");
      end
      cyc(0, 0, 0, 0, 0, 0, 2'b00, 0, 0, "R10");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule